// File: doc/BRIEF.md
# Two-Region Bus Wait-State Controller

This block stretches each external bus cycle issued by a CPU core by a programmed number of wait clocks. The core raises a start strobe together with a memory/I/O qualifier and a 19-bit physical address. The controller then asserts a hold signal that stalls the core for every clock of the cycle except the last one. On the final clock it pulses a done signal. Memory space is split into a lower and an upper half, and the top address bit picks the half. Each half has its own mode setting, and I/O cycles have a third setting.

Each setting chooses between a fixed short cycle and a longer base count that an external ready input can extend. Memory can be set to no wait at all, or to one wait plus any extension that ready adds. I/O can be set to exactly one wait, or to two waits plus any extension. A three-bit configuration register, loaded through a write strobe, holds the three settings. Out of reset all three select the slow, extendable option.

Top module: `bus_wait_ctrl`

## Requirements
- R1: Address bit 18 of a memory cycle selects the mode. When it is 0, configuration bit 0 applies. When it is 1, configuration bit 1 applies. I/O cycles use configuration bit 2.
- R2: A memory cycle whose mode bit is 0 finishes in its start clock. In that clock done is high and hold is low, whatever the level of ready.
- R3: A memory cycle whose mode bit is 1 holds for one clock. From the next clock on, each clock in which ready is low adds one more hold clock. The cycle ends on the first such clock in which ready is high. The level of ready on earlier clocks has no effect.
- R4: An I/O cycle with configuration bit 2 at 0 lasts exactly two clocks (one hold clock, then done), whatever the level of ready.
- R5: An I/O cycle with configuration bit 2 at 1 holds for two clocks. Ready is then sampled from the third clock on, and the cycle ends on the first clock in which ready is high.
- R6: After reset, the configuration is 3'b111. Hold and done are low while no cycle is running.
- R7: A configuration write sets all three bits from the write data. The new value applies only to cycles that start after the write clock. A cycle that starts in the same clock as the write uses the old value.
- R8: Done is high for exactly one clock at the end of every cycle. Hold is high on every other clock of the cycle and low outside cycles. Hold and done are never high together.
- R9: A start strobe raised while a cycle is in progress is ignored. The running cycle keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration data: bit0 lower half, bit1 upper half, bit2 I/O (1 = extendable) |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_addr | input | 19 | Physical address of the cycle |
| rdy | input | 1 | External ready, low requests more wait clocks |
| hold | output | 1 | Stalls the core on every non-final clock of a cycle |
| cyc_done | output | 1 | One-clock pulse on the final clock of a cycle |

## Verification
Cycles are run in every combination of the three mode bits, with addresses just below and just above the half boundary. This shows that the region bit really selects its own setting. Ready is held low for zero, one and several clocks past the base count. The same low ready is also applied to fixed-mode cycles, which separates the extendable modes from those that must ignore ready. Runs of back-to-back zero-wait cycles, a configuration write in the same clock as a start, and a second start strobe inside a running cycle check the timing of the configuration register and the rejection of starts while busy.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    localparam int CNT_W = 2;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] base;
        logic             ext;
    } seq_state_t;
endpackage

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg #(
    parameter int          NUM_SET = 3,
    parameter logic [NUM_SET-1:0] RST_VAL = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NUM_SET-1:0] wdata,
    output logic [NUM_SET-1:0] cfg
);
    logic [NUM_SET-1:0] cfg_d, cfg_q;

    for (genvar i = 0; i < NUM_SET; i++) begin : g_bit
        always_comb begin
            cfg_d[i] = cfg_q[i];
            if (we) cfg_d[i] = wdata[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q[i] <= RST_VAL[i];
            else        cfg_q[i] <= cfg_d[i];
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bwc_mode_sel.sv
module bwc_mode_sel #(
    parameter int ADDR_W       = 19,
    parameter int CNT_W        = 2,
    parameter int MEM_SLOW_BASE = 1,
    parameter int IO_FAST_BASE  = 1,
    parameter int IO_SLOW_BASE  = 2
) (
    input  logic              is_io,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        cfg,
    output logic [CNT_W-1:0]  base,
    output logic              ext
);
    localparam int REGION_BIT = ADDR_W - 1;

    logic mem_slow;

    always_comb begin
        mem_slow = addr[REGION_BIT] ? cfg[1] : cfg[0];
        if (is_io) begin
            ext  = cfg[2];
            base = cfg[2] ? CNT_W'(IO_SLOW_BASE) : CNT_W'(IO_FAST_BASE);
        end else begin
            ext  = mem_slow;
            base = mem_slow ? CNT_W'(MEM_SLOW_BASE) : '0;
        end
    end
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
    import bwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] base_in,
    input  logic             ext_in,
    input  logic             rdy,
    output logic             hold,
    output logic             done,
    output logic             busy
);
    seq_state_t st_d, st_q;
    logic       at_end;

    always_comb begin
        st_d   = st_q;
        hold   = 1'b0;
        done   = 1'b0;
        at_end = (st_q.cnt >= st_q.base);
        if (!st_q.busy) begin
            if (start) begin
                if (base_in == '0) begin
                    done = 1'b1;
                end else begin
                    hold      = 1'b1;
                    st_d.busy = 1'b1;
                    st_d.cnt  = CNT_W'(1);
                    st_d.base = base_in;
                    st_d.ext  = ext_in;
                end
            end
        end else begin
            if (at_end && (!st_q.ext || rdy)) begin
                done      = 1'b1;
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                hold = 1'b1;
                if (!at_end) st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_wdata,
    input  logic              cyc_start,
    input  logic              cyc_is_io,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              rdy,
    output logic              hold,
    output logic              cyc_done
);
    logic [2:0]       cfg_w;
    logic [CNT_W-1:0] base_w;
    logic             ext_w;
    logic             busy_w;

    bwc_cfg_reg #(.NUM_SET(3), .RST_VAL(3'b111)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_w)
    );

    bwc_mode_sel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mode (
        .is_io (cyc_is_io),
        .addr  (cyc_addr),
        .cfg   (cfg_w),
        .base  (base_w),
        .ext   (ext_w)
    );

    bwc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .base_in (base_w),
        .ext_in  (ext_w),
        .rdy     (rdy),
        .hold    (hold),
        .done    (cyc_done),
        .busy    (busy_w)
    );
endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_wdata,
    input logic              cyc_start,
    input logic              cyc_is_io,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              hold,
    input logic              cyc_done,
    input logic              busy,
    input logic [2:0]        cfg
);
    logic new_mem;
    assign new_mem = !busy && cyc_start && !cyc_is_io;

    assert_zero_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        new_mem && !cfg[cyc_addr[ADDR_W-1]] |-> cyc_done && !hold);

    assert_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        new_mem && cfg[cyc_addr[ADDR_W-1]] |-> hold && !cyc_done);

    assert_io_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cyc_start && cyc_is_io && !cfg[2] |=> cyc_done);

    assert_cfg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg == $past(cfg_wdata));

    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && cyc_done));

    assert_hold_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (hold || cyc_done));

    assert_busy_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (hold || cyc_done));
endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cyc_start (cyc_start),
    .cyc_is_io (cyc_is_io),
    .cyc_addr  (cyc_addr),
    .hold      (hold),
    .cyc_done  (cyc_done),
    .busy      (busy_w),
    .cfg       (cfg_w)
);

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic        cyc_is_io = 1'b0;
    logic [18:0] cyc_addr = '0;
    logic        rdy = 1'b1;
    logic        hold;
    logic        cyc_done;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] tb_cfg = 3'b111;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    bus_wait_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cyc_start(cyc_start), .cyc_is_io(cyc_is_io), .cyc_addr(cyc_addr),
        .rdy(rdy), .hold(hold), .cyc_done(cyc_done)
    );

    function automatic int base_of(logic io, logic [18:0] a, logic [2:0] c);
        if (io) return c[2] ? 2 : 1;
        return c[a[18]] ? 1 : 0;
    endfunction

    function automatic int len_of(logic io, logic [18:0] a, int k, logic [2:0] c);
        logic ext;
        ext = io ? c[2] : c[a[18]];
        return 1 + base_of(io, a, c) + (ext ? k : 0);
    endfunction

    task automatic write_cfg(logic [2:0] v);
        @(negedge clk);
        cyc_start = 1'b0;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        tb_cfg    = v;
    endtask

    // Driver: pushes the expected length, then plays one cycle. Ready stays
    // low for base+k clocks counted from the start clock.
    task automatic run_cyc(logic io, logic [18:0] a, int k, bit extra_start,
                           bit wr, logic [2:0] wv, string tag);
        int lowcnt;
        int idx;
        lowcnt = base_of(io, a, tb_cfg) + k;
        exp_q.push_back(len_of(io, a, k, tb_cfg));
        tag_q.push_back(tag);
        idx = 0;
        forever begin
            @(negedge clk);
            cyc_start = (idx == 0) || (extra_start && idx == 1);
            cyc_is_io = io;
            cyc_addr  = a;
            rdy       = (idx >= lowcnt);
            cfg_we    = wr && (idx == 0);
            cfg_wdata = wv;
            #5;
            if (cyc_done) break;
            idx++;
            if (idx > 40) break;
        end
        if (wr) tb_cfg = wv;
    endtask

    // Monitor: measures each cycle at the ports and compares with the queue.
    bit in_cyc = 1'b0;
    int len = 0;
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n) begin
                if (hold && cyc_done) begin
                    n_chk++; n_bad++;
                    $display("FAIL R8: hold=%0b done=%0b expected not both high", hold, cyc_done);
                end
                if (!in_cyc && cyc_start) begin
                    in_cyc = 1'b1;
                    len = 0;
                end
                if (in_cyc) begin
                    len++;
                    if (!hold && !cyc_done) begin
                        n_chk++; n_bad++;
                        $display("FAIL R8: hold=0 done=0 inside cycle, expected one high");
                    end
                    if (cyc_done) begin
                        in_cyc = 1'b0;
                        n_chk++;
                        if (exp_q.size() == 0) begin
                            n_bad++;
                            $display("FAIL R8: unexpected done, actual len %0d expected none", len);
                        end else begin
                            int e;
                            string t;
                            e = exp_q.pop_front();
                            t = tag_q.pop_front();
                            if (len != e) begin
                                n_bad++;
                                $display("FAIL %s: cycle length %0d expected %0d", t, len, e);
                            end
                        end
                    end
                end else if (hold) begin
                    n_chk++; n_bad++;
                    $display("FAIL R8: hold=1 outside a cycle, expected 0");
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        n_chk++;
        if (hold !== 1'b0 || cyc_done !== 1'b0) begin
            n_bad++;
            $display("FAIL R6: idle hold=%0b done=%0b expected 0/0", hold, cyc_done);
        end

        // Reset defaults: all extendable
        run_cyc(0, 19'h00010, 0, 0, 0, 3'b000, "R6");
        run_cyc(0, 19'h40010, 2, 0, 0, 3'b000, "R3");
        run_cyc(1, 19'h00002, 0, 0, 0, 3'b000, "R6");
        run_cyc(1, 19'h00002, 3, 0, 0, 3'b000, "R5");
        run_cyc(0, 19'h00100, 1, 0, 0, 3'b000, "R3");

        // All fixed: ready low must be ignored
        write_cfg(3'b000);
        run_cyc(0, 19'h00000, 3, 0, 0, 3'b000, "R2");
        run_cyc(0, 19'h7FFFF, 2, 0, 0, 3'b000, "R2");
        run_cyc(0, 19'h12345, 0, 0, 0, 3'b000, "R2");
        run_cyc(1, 19'h00005, 2, 0, 0, 3'b000, "R4");
        run_cyc(1, 19'h00005, 0, 0, 0, 3'b000, "R4");

        // Only the upper half extendable
        write_cfg(3'b010);
        run_cyc(0, 19'h3FFFF, 2, 0, 0, 3'b000, "R1");
        run_cyc(0, 19'h40000, 1, 0, 0, 3'b000, "R1");
        run_cyc(0, 19'h3FFFF, 0, 0, 0, 3'b000, "R1");

        // Only the lower half and I/O extendable
        write_cfg(3'b101);
        run_cyc(0, 19'h00000, 0, 0, 0, 3'b000, "R1");
        run_cyc(0, 19'h40000, 2, 0, 0, 3'b000, "R1");
        run_cyc(1, 19'h00001, 1, 0, 0, 3'b000, "R5");

        // Write in the start clock: old value applies, new one next
        run_cyc(1, 19'h00001, 1, 0, 1, 3'b000, "R7");
        run_cyc(1, 19'h00001, 1, 0, 0, 3'b000, "R7");
        run_cyc(0, 19'h00000, 2, 0, 0, 3'b000, "R7");

        // Second start inside a running cycle
        write_cfg(3'b100);
        run_cyc(1, 19'h00003, 2, 1, 0, 3'b000, "R9");
        run_cyc(0, 19'h00000, 0, 0, 0, 3'b000, "R9");

        @(negedge clk);
        cyc_start = 1'b0;
        rdy = 1'b1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d cycles never completed, expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule